// File: doc/BRIEF.md
# Two-Pulse Acknowledge Interrupt Controller

This block gathers up to eight device request lines and presents a single interrupt line to a processor that acknowledges with two pulses. A rising edge on a request line sets a sticky pending bit. A mask register hides selected lines from the processor without losing their pending state. When a pending, unmasked request outranks every request already being serviced, the interrupt output goes high. Line 0 has the highest rank.

The processor answers with two acknowledge pulses. On the first pulse the block picks the winning line, clears its pending bit and sets the matching in-service bit. On the second pulse it places an identifier on the data bus for one cycle. The identifier is the programmed base plus the line number. Software uses a small write port to change the mask, to program the base, and to issue end-of-interrupt. End-of-interrupt retires the highest-ranked line in service.

Top module: `ack_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` and `vec_valid_o` are 0, the mask and the vector base are 0, and nothing is pending or in service.
- R2: A request line is sampled every clock. A 0-to-1 transition sets that line's pending bit, which then stays set until the line is acknowledged. Holding a line high creates no further request.
- R3: `irq_o` is high when all of these hold: some unmasked line is pending, that line ranks above every in-service line, and the block is not between the two acknowledge pulses.
- R4: A write with `reg_addr_i`=0 loads the mask from `reg_wdata_i` (bit n set hides line n). A masked line keeps its pending bit and raises `irq_o` once it is unmasked.
- R5: Among the candidates, the lowest-numbered line wins.
- R6: The first acknowledge pulse clears the winner's pending bit, sets its in-service bit and drops `irq_o`. It puts nothing on the bus.
- R7: In the cycle after the second acknowledge pulse is sampled, `vec_valid_o` is 1 for exactly one cycle. At the same time `vec_o` equals (base + line number) modulo 256.
- R8: A write with `reg_addr_i`=1 is end-of-interrupt. It clears only the lowest-numbered in-service bit.
- R9: A line in service blocks itself and all higher-numbered lines. A lower-numbered line can still interrupt it, so service can nest.
- R10: If nothing qualifies at the first pulse, no state changes. The second pulse then returns base + 7.
- R11: A new rising edge on a line in the same cycle as that line's first acknowledge leaves the line pending.
- R12: A write with `reg_addr_i`=2 loads the vector base from `reg_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Device request lines, edge sensitive |
| ack_i | input | 1 | Acknowledge pulse from the processor, one cycle per pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 end-of-interrupt, 2 vector base |
| reg_wdata_i | input | 8 | Register write data |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Identifier on the bus is valid |
| vec_o | output | 8 | Interrupt identifier |

## Verification
Two functions can act on the same line in the same cycle: edge capture setting a pending bit, and the first acknowledge clearing it. The bench provokes this by raising a line that is already pending in exactly the cycle the first acknowledge pulse is sampled. It judges the result at the ports. After end-of-interrupt, `irq_o` must rise again and a second handshake must return the same identifier. A nested sequence also places end-of-interrupt against two in-service lines and checks which one it retired.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W     = 8;
  localparam int MAX_LINES = 32;
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_EOI  = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;

  // index of lowest set bit, 32 when none is set
  function automatic logic [5:0] low_index(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd32;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  // isolate lowest set bit
  function automatic logic [31:0] low_bit(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  // identifier = base + line, wrapping
  function automatic logic [VEC_W-1:0] vec_id(input logic [VEC_W-1:0] base,
                                              input logic [4:0] idx);
    return base + VEC_W'(idx);
  endfunction
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               take_i,
  input  logic [N_LINES-1:0] take_mask_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] rise_w;
  logic [N_LINES-1:0] clr_w;

  assign rise_w = req_i & ~req_q;
  assign clr_w  = take_i ? take_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_w) | rise_w;
    end
  end

  assign pend_o = pend_q;

  a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((pend_q & $past(rise_w)) == $past(rise_w)));

  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ((rise_w & take_mask_i) != '0)) |=> ((pend_q & $past(take_mask_i)) != '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  output logic               fwd_o,
  output logic [IW-1:0]      sel_idx_o
);
  import irq_pkg::*;
  logic [N_LINES-1:0] cand_w;
  logic [5:0]         cand_low_w;
  logic [5:0]         serv_low_w;

  assign cand_w     = pend_i & ~mask_i;
  assign cand_low_w = low_index(32'(cand_w));
  assign serv_low_w = low_index(32'(isr_i));
  // none-found codes as 32, so an empty set never wins and never blocks
  assign fwd_o      = cand_low_w < serv_low_w;
  assign sel_idx_o  = IW'(cand_low_w);
endmodule

// File: rtl/irq_svc.sv
module irq_svc #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_i,
  input  logic                      fwd_i,
  input  logic [IW-1:0]             sel_idx_i,
  input  logic                      eoi_i,
  input  logic [irq_pkg::VEC_W-1:0] base_i,
  output logic                      take_o,
  output logic [N_LINES-1:0]        take_mask_o,
  output logic [N_LINES-1:0]        isr_o,
  output logic                      phase_o,
  output logic                      vec_valid_o,
  output logic [irq_pkg::VEC_W-1:0] vec_o
);
  import irq_pkg::*;
  localparam logic [IW-1:0] SPUR_IDX = IW'(N_LINES - 1);

  logic [N_LINES-1:0] isr_q;
  logic               phase_q;
  logic [IW-1:0]      held_idx_q;
  logic               vld_q;
  logic [VEC_W-1:0]   vec_q;
  logic [N_LINES-1:0] eoi_mask_w;

  assign take_o      = ack_i & ~phase_q & fwd_i;
  assign take_mask_o = N_LINES'(1) << sel_idx_i;
  assign eoi_mask_w  = eoi_i ? N_LINES'(low_bit(32'(isr_q))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q      <= '0;
      phase_q    <= 1'b0;
      held_idx_q <= '0;
      vld_q      <= 1'b0;
      vec_q      <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_mask_w) | (take_o ? take_mask_o : '0);
      vld_q <= 1'b0;
      vec_q <= '0;
      if (ack_i && !phase_q) begin
        phase_q    <= 1'b1;
        held_idx_q <= fwd_i ? sel_idx_i : SPUR_IDX;
      end else if (ack_i && phase_q) begin
        phase_q <= 1'b0;
        vld_q   <= 1'b1;
        vec_q   <= vec_id(base_i, 5'(held_idx_q));
      end
    end
  end

  assign isr_o       = isr_q;
  assign phase_o     = phase_q;
  assign vec_valid_o = vld_q;
  assign vec_o       = vec_q;

  a_r6_take_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> ((isr_q & $past(take_mask_o)) != '0));

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  a_r7_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(ack_i) && !phase_q));

  a_r8_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !take_o && isr_q != '0) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

// File: rtl/ack_irq_ctrl.sv
module ack_irq_ctrl #(
  parameter int N_LINES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        req_i,
  input  logic                      ack_i,
  input  logic                      reg_we_i,
  input  logic [1:0]                reg_addr_i,
  input  logic [irq_pkg::VEC_W-1:0] reg_wdata_i,
  output logic                      irq_o,
  output logic                      vec_valid_o,
  output logic [irq_pkg::VEC_W-1:0] vec_o
);
  import irq_pkg::*;
  localparam int IW = $clog2(N_LINES);

  logic [N_LINES-1:0] mask_q;
  logic [VEC_W-1:0]   base_q;
  logic [N_LINES-1:0] pend_w;
  logic [N_LINES-1:0] isr_w;
  logic [N_LINES-1:0] take_mask_w;
  logic [IW-1:0]      sel_idx_w;
  logic               fwd_w;
  logic               take_w;
  logic               phase_w;
  logic               eoi_w;

  assign eoi_w = reg_we_i && (reg_addr_i == ADDR_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_MASK) mask_q <= N_LINES'(reg_wdata_i);
      if (reg_addr_i == ADDR_BASE) base_q <= reg_wdata_i;
    end
  end

  irq_edge_pend #(.N_LINES(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .take_i(take_w), .take_mask_i(take_mask_w), .pend_o(pend_w)
  );

  irq_prio #(.N_LINES(N_LINES)) u_prio (
    .pend_i(pend_w), .mask_i(mask_q), .isr_i(isr_w),
    .fwd_o(fwd_w), .sel_idx_o(sel_idx_w)
  );

  irq_svc #(.N_LINES(N_LINES)) u_svc (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .fwd_i(fwd_w),
    .sel_idx_i(sel_idx_w), .eoi_i(eoi_w), .base_i(base_q),
    .take_o(take_w), .take_mask_o(take_mask_w), .isr_o(isr_w),
    .phase_o(phase_w), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  assign irq_o = fwd_w & ~phase_w;

  a_r3_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_w & ~mask_q) != '0));

  a_r4_masked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_w) |=> ((pend_w & $past(pend_w)) == $past(pend_w)));
endmodule

// File: tb/ack_irq_ctrl_bench.sv
module ack_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       ack = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       irq;
  logic       vvalid;
  logic [7:0] vec;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ack_irq_ctrl u_ack_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .irq_o(irq), .vec_valid_o(vvalid), .vec_o(vec)
  );

  // mask, base, request pattern, expected irq, expected identifier
  localparam logic [35:0] TBL [6] = '{
    {8'h00, 8'h20, 8'h01, 4'h1, 8'h20},
    {8'h00, 8'h40, 8'h18, 4'h1, 8'h43},
    {8'h08, 8'h40, 8'h18, 4'h1, 8'h44},
    {8'hFF, 8'h10, 8'h81, 4'h0, 8'h00},
    {8'h7F, 8'hFC, 8'h80, 4'h1, 8'h03},
    {8'h00, 8'h00, 8'hA0, 4'h1, 8'h05}
  };

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; ack = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] m);
    @(negedge clk);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // full handshake, checks the identifier and its one-cycle window
  task automatic handshake(input string rq, input logic [7:0] exp_vec);
    do_ack();
    chk({rq, " irq low after first ack (R6)"}, 8'(irq), 8'h0);
    chk({rq, " no bus after first ack (R6)"}, 8'(vvalid), 8'h0);
    do_ack();
    chk({rq, " valid after second ack (R7)"}, 8'(vvalid), 8'h1);
    chk({rq, " identifier (R7)"}, vec, exp_vec);
    @(negedge clk);
    chk({rq, " valid one cycle only (R7)"}, 8'(vvalid), 8'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state, and R10 spurious handshake returns base(0)+7
    do_reset();
    chk("R1 irq after reset", 8'(irq), 8'h0);
    chk("R1 valid after reset", 8'(vvalid), 8'h0);
    handshake("R10 spurious", 8'h07);

    // table walk: R3 R4 R5 R12
    for (int i = 0; i < 6; i++) begin
      logic [7:0] m, b, r, ev;
      logic [3:0] ei;
      {m, b, r, ei, ev} = TBL[i];
      do_reset();
      wr(2'd0, m);
      wr(2'd2, b);
      pulse_req(r);
      chk("R3/R4 irq from table", 8'(irq), 8'(ei[0]));
      if (ei[0]) handshake("R5/R12 table", ev);
    end

    // R4 masked request stays pending and fires on unmask
    do_reset();
    wr(2'd0, 8'h04);
    pulse_req(8'h04);
    chk("R4 masked no irq", 8'(irq), 8'h0);
    wr(2'd0, 8'h00);
    chk("R4 irq after unmask", 8'(irq), 8'h1);
    handshake("R4 unmasked", 8'h02);

    // R2 held level gives one request only
    do_reset();
    @(negedge clk); req = 8'h08;
    @(negedge clk);
    chk("R2 edge latched", 8'(irq), 8'h1);
    handshake("R2 held", 8'h03);
    wr(2'd1, 8'h00);
    chk("R2 held level no new request", 8'(irq), 8'h0);
    @(negedge clk); req = 8'h00;
    @(negedge clk); req = 8'h08;
    @(negedge clk); req = 8'h00;
    chk("R2 new edge after drop", 8'(irq), 8'h1);

    // R9 nesting, R8 end-of-interrupt retires lowest line only
    do_reset();
    pulse_req(8'h10);
    handshake("R9 line4", 8'h04);
    pulse_req(8'h40);
    chk("R9 lower rank blocked", 8'(irq), 8'h0);
    pulse_req(8'h10);
    chk("R9 equal rank blocked", 8'(irq), 8'h0);
    pulse_req(8'h02);
    chk("R9 higher rank nests", 8'(irq), 8'h1);
    handshake("R9 line1", 8'h01);
    wr(2'd1, 8'h00);
    chk("R8 eoi retires line1 only", 8'(irq), 8'h0);
    wr(2'd1, 8'h00);
    chk("R8 eoi retires line4", 8'(irq), 8'h1);
    handshake("R8 line4 again", 8'h04);
    wr(2'd1, 8'h00);
    handshake("R8 line6", 8'h06);

    // R11 new edge in the same cycle as the first acknowledge
    do_reset();
    pulse_req(8'h04);
    @(negedge clk); ack = 1'b1; req = 8'h04;
    @(negedge clk); ack = 1'b0; req = 8'h00;
    do_ack();
    chk("R11 identifier", vec, 8'h02);
    wr(2'd1, 8'h00);
    chk("R11 line still pending", 8'(irq), 8'h1);
    handshake("R11 second service", 8'h02);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule